// File: doc/BRIEF.md
# STS-12 Transport Overhead Inserter

This block sits in the transmit path of a byte-wide STS-12 stream. One byte arrives on each clock. A row/column position counter follows the frame, and it is re-zeroed whenever the frame-start strobe is high. At each transport overhead position the block selects the output byte from one of several sources:

- regenerated framing bytes;
- a recomputed section parity byte;
- forced zeros;
- the payload input, which carries the pointer bytes;
- a side overhead input that is already aligned to frame position.

Bytes outside the overhead always come from the payload input. The output is registered, so it lags the inputs by one clock and carries its own frame-start strobe.

Geometry is set by three parameters:

- `NUM_STS`: the number of interleaved STS-1s (default 12).
- `STS_COLS`: the columns per STS-1 in a row (default 90).
- `ROWS`: the rows per frame (default 9).

The overhead occupies the first `3*NUM_STS` columns of every row. Column group g (g = 0, 1, 2) spans columns g*NUM_STS to g*NUM_STS+NUM_STS-1.

Top module: `sts_oh_inserter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `data_out` is 0x00 and `sof_out` is 0. The position counter restarts at row 0, column 0.
- R2: Each input byte appears at the output one clock later. `sof_out` is 1 exactly for the output byte at row 0, column 0. This includes the frame start reached by wrapping after `ROWS*NUM_STS*STS_COLS` bytes when `sof_in` is 0.
- R3: In row 0, columns of group 0 output 0xF6 and columns of group 1 output 0x28, whatever the two inputs carry.
- R4: The byte at row 1, column 0 is the even-parity BIP-8 (the XOR) of every output byte from the previous frame start up to the byte before the current frame start.
- R5: In the first frame after reset, the byte at row 1, column 0 is 0x00.
- R6: In row 1, columns 1 to NUM_STS-1 output 0x00.
- R7: In row 3, all overhead columns (groups 0 to 2) pass the payload input byte through.
- R8: Every other overhead position outputs the overhead input byte. These positions are row 0 group 2, row 1 groups 1 and 2, and all overhead columns of rows 2 and 4 to ROWS-1.
- R9: Columns at or above `3*NUM_STS` output the payload input byte.
- R10: `sof_in` high in the middle of a frame re-zeroes the position counter on that byte. That byte is treated as row 0, column 0, and the parity restarts from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_in | input | 8 | Payload stream byte |
| sof_in | input | 1 | Marks the current input byte as frame position (0,0) |
| oh_in | input | 8 | Overhead byte for the current frame position |
| data_out | output | 8 | Assembled stream byte |
| sof_out | output | 1 | Marks the output byte at frame position (0,0) |

## Verification
The bench builds the block with `NUM_STS=3`, `STS_COLS=10` and `ROWS=9`, which gives a 270-byte frame with 9 overhead columns per row. This short frame lets a single run cover several complete frames, including the first frame with its 0x00 parity byte, the parity carried from one frame into the next, a frame start reached only by counter wrap, and a mid-frame strobe that realigns both the position and the parity. With three STS-1s, the zeroed run after the parity byte still has more than one byte, and each of the three column groups is distinct.

// File: rtl/sts_oh_inserter.sv
module sts_oh_inserter #(
  parameter int NUM_STS  = 12,
  parameter int STS_COLS = 90,
  parameter int ROWS     = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pay_in,
  input  logic       sof_in,
  input  logic [7:0] oh_in,
  output logic [7:0] data_out,
  output logic       sof_out
);
  localparam int ROW_LEN = NUM_STS * STS_COLS;
  localparam int CW = $clog2(ROW_LEN);
  localparam int RW = $clog2(ROWS);
  localparam logic [CW-1:0] GRP1 = CW'(NUM_STS);
  localparam logic [CW-1:0] GRP2 = CW'(2 * NUM_STS);
  localparam logic [CW-1:0] TOH_END = CW'(3 * NUM_STS);
  localparam logic [CW-1:0] LAST_COL = CW'(ROW_LEN - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [7:0]    acc, b1_hold, out_byte;
  logic          seen;

  wire [CW-1:0] cur_col  = sof_in ? '0 : col;
  wire [RW-1:0] cur_row  = sof_in ? '0 : row;
  wire          at_start = (cur_row == 0) && (cur_col == 0);
  wire          in_toh   = cur_col < TOH_END;

  always_comb begin
    if (!in_toh)                          out_byte = pay_in;
    else if (cur_row == 0 && cur_col < GRP1) out_byte = 8'hF6;
    else if (cur_row == 0 && cur_col < GRP2) out_byte = 8'h28;
    else if (cur_row == 1 && cur_col == 0)   out_byte = b1_hold;
    else if (cur_row == 1 && cur_col < GRP1) out_byte = 8'h00;
    else if (cur_row == 3)                   out_byte = pay_in;
    else                                     out_byte = oh_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      row      <= '0;
      acc      <= '0;
      b1_hold  <= '0;
      seen     <= 1'b0;
      data_out <= '0;
      sof_out  <= 1'b0;
    end else begin
      data_out <= out_byte;
      sof_out  <= at_start;
      if (cur_col == LAST_COL) begin
        col <= '0;
        row <= (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
      end else begin
        col <= cur_col + 1'b1;
        row <= cur_row;
      end
      if (at_start) begin
        acc     <= out_byte;
        b1_hold <= seen ? acc : 8'h00;
        seen    <= 1'b1;
      end else begin
        acc <= acc ^ out_byte;
      end
    end
  end

  a_r2_sof_follows: assert property (@(posedge clk) disable iff (rst)
    sof_in |=> sof_out);
  a_r3_frame_starts_a1: assert property (@(posedge clk) disable iff (rst)
    sof_out |-> data_out == 8'hF6);
  a_r6_zero_run: assert property (@(posedge clk) disable iff (rst)
    (cur_row == 1 && cur_col != 0 && cur_col < GRP1) |=> data_out == 8'h00);
  a_r7_pointer_pass: assert property (@(posedge clk) disable iff (rst)
    (cur_row == 3 && in_toh) |=> data_out == $past(pay_in));
  a_r8_overhead_take: assert property (@(posedge clk) disable iff (rst)
    (cur_row == 2 && in_toh) |=> data_out == $past(oh_in));
  a_r9_payload_pass: assert property (@(posedge clk) disable iff (rst)
    !in_toh |=> data_out == $past(pay_in));
endmodule

// File: tb/sts_oh_inserter_tb.sv
module sts_oh_inserter_tb;
  localparam int NS = 3, SC = 10, NR = 9;
  localparam int RL = NS * SC, FL = RL * NR;

  typedef struct {
    logic [7:0] d;
    logic       s;
    string      dtag;
    string      stag;
  } item_t;

  logic clk = 0, rst = 1;
  logic [7:0] pay_in = 0, oh_in = 0;
  logic sof_in = 0;
  logic [7:0] data_out;
  logic sof_out;

  sts_oh_inserter #(.NUM_STS(NS), .STS_COLS(SC), .ROWS(NR)) u_dut (
    .clk(clk), .rst(rst), .pay_in(pay_in), .sof_in(sof_in), .oh_in(oh_in),
    .data_out(data_out), .sof_out(sof_out));

  always #5 clk = ~clk;

  item_t q[$];
  int checks = 0, fails = 0;
  int brow = 0, bcol = 0, starts = 0;
  logic [7:0] bacc = 0, bb1 = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic s, logic [7:0] p, logic [7:0] o);
    item_t it;
    int r, c;
    r = s ? 0 : brow;
    c = s ? 0 : bcol;
    it.stag = (s && !(brow == 0 && bcol == 0)) ? "R10" : "R2";
    if (c >= 3*NS)                  begin it.d = p;     it.dtag = "R9"; end
    else if (r == 0 && c < NS)      begin it.d = 8'hF6; it.dtag = "R3"; end
    else if (r == 0 && c < 2*NS)    begin it.d = 8'h28; it.dtag = "R3"; end
    else if (r == 1 && c == 0)      begin it.d = bb1;   it.dtag = (starts == 1) ? "R5" : "R4"; end
    else if (r == 1 && c < NS)      begin it.d = 8'h00; it.dtag = "R6"; end
    else if (r == 3)                begin it.d = p;     it.dtag = "R7"; end
    else                            begin it.d = o;     it.dtag = "R8"; end
    it.s = (r == 0 && c == 0);
    if (it.s) begin
      bb1 = (starts == 0) ? 8'h00 : bacc;
      bacc = it.d;
      starts++;
    end else bacc = bacc ^ it.d;
    if (c == RL - 1) begin bcol = 0; brow = (r == NR - 1) ? 0 : r + 1; end
    else begin bcol = c + 1; brow = r; end
    q.push_back(it);
    pay_in = p; oh_in = o; sof_in = s;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(e.dtag, data_out, e.d);
      chk(e.stag, sof_out, e.s);
    end
  end

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", data_out, 0);
    chk("R1", sof_out, 0);
    rst = 0;
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < FL; i++)
        send(i == 0, 8'($urandom), 8'($urandom));
    for (int i = 0; i < FL; i++)
      send(1'b0, 8'($urandom), 8'($urandom));
    for (int i = 0; i < 100; i++)
      send(1'b0, 8'($urandom), 8'($urandom));
    for (int i = 0; i < 2 * FL; i++)
      send(i == 0 || i == FL, 8'($urandom), 8'($urandom));
    for (int i = 0; i < 40; i++)
      send(1'b0, 8'hFF, 8'hFF);
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule